// File: doc/BRIEF.md
# Wavefront-Scheduled Systolic Matrix Multiplier

This block multiplies a ROWS x DEPTH matrix A by a DEPTH x COLS matrix B. A grid of ROWS x COLS multiply-accumulate cells does the work. Operand B is held in one small memory per grid column, where memory c stores column c of B at address k. Operand A is held in one memory per grid row, where memory r stores row r of A at address k. Both sets of memories are filled through two plain write ports while the block is idle.

A pulse on `start` begins a run. The sequencer first clears every accumulator. It then loads every operand address counter with all-ones and advances the counters of the two corner memories. After that it walks through ROWS+COLS+DEPTH-2 timesteps.

Each timestep has two phases:
- A move phase of one cycle. In it, the active edge cells load operands from their memories and the inner cells take operands from their upper and left neighbours.
- A compute phase of five cycles. In it, the sequencer advances the address counters needed by the next step, and the active cells run a multiply of four cycles followed by an accumulate of one cycle.

The cell at row r, column c is active on timesteps r+c through r+c+DEPTH-1. After the last step, the results leave through a single output write port, one per cycle in row-major order. A one-cycle `done` pulse follows the last write.

Top module: `wavefront_matmul`

## Requirements
- R1: While reset is held and right after it is released, `done` and `out_we` are 0.
- R2: The written results equal C[r][c] = sum over k of A[r][k]*B[k][c]. Here A[r][k] is left memory r at address k, and B[k][c] is top memory c at address k.
- R3: The results come out on `out_we` in ROWS*COLS consecutive cycles, in row-major order. `out_row` carries the row and `out_col` carries the column, starting at (0,0).
- R4: `done` is high for exactly one cycle. That cycle immediately follows the cycle of the write to (ROWS-1, COLS-1).
- R5: The first output write is visible after the (6*(ROWS+COLS+DEPTH-2)+4)-th rising edge, counting from the edge that samples `start` as edge 1.
- R6: Every run starts from zeroed accumulators. Repeating a run on the same operands gives the same results.
- R7: A `start` pulse during a run is ignored: the timing and the results are unchanged.
- R8: Arithmetic is unsigned and keeps the low 32 bits of every product and every sum.
- R9: A configuration whose top operand depth differs from its left operand depth is rejected at elaboration.
- R10: Each operand memory is used from address 0 up to address DEPTH-1, in that order. The first use happens after the all-ones index wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request, sampled while idle |
| top_we | input | 1 | Top operand memory write enable |
| top_sel | input | CW | Top memory (grid column) select |
| top_addr | input | IW | Top memory address (k) |
| top_wdata | input | 32 | Top memory write data |
| left_we | input | 1 | Left operand memory write enable |
| left_sel | input | RW | Left memory (grid row) select |
| left_addr | input | IW | Left memory address (k) |
| left_wdata | input | 32 | Left memory write data |
| out_we | output | 1 | Result write strobe |
| out_row | output | RW | Result row address |
| out_col | output | CW | Result column address |
| out_data | output | 32 | Result value |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two directed patterns place nonzero operands only at address 0 or only at address DEPTH-1. A wrong wrap of the all-ones index, or a shifted index, shows up as zero or misplaced results. Operands of all ones give a product of 1 per term, so dropping the upper bits is told apart from any wider arithmetic. Seeded random operands, both small and full-width, exercise the neighbour forwarding across the whole wavefront. A repeated run tells cleared accumulators from stale ones, and a run with a stray start pulse inside it shows that the pulse is ignored.

// File: rtl/wavefront_matmul.sv
module wavefront_matmul #(
  parameter int ROWS       = 2,
  parameter int COLS       = 3,
  parameter int TOP_DEPTH  = 4,
  parameter int LEFT_DEPTH = 4,
  localparam int DEPTH = TOP_DEPTH,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          top_we,
  input  logic [CW-1:0] top_sel,
  input  logic [IW-1:0] top_addr,
  input  logic [31:0]   top_wdata,
  input  logic          left_we,
  input  logic [RW-1:0] left_sel,
  input  logic [IW-1:0] left_addr,
  input  logic [31:0]   left_wdata,
  output logic          out_we,
  output logic [RW-1:0] out_row,
  output logic [CW-1:0] out_col,
  output logic [31:0]   out_data,
  output logic          done
);
  localparam int NSTEP = ROWS + COLS + DEPTH - 2;
  localparam int SW    = $clog2(NSTEP + 1);

  // R9: depth mismatch is a configuration error
  if (TOP_DEPTH != LEFT_DEPTH) begin : g_depth_mismatch
    $error("top and left operand depths differ");
  end

  typedef enum logic [2:0] {
    S_IDLE, S_CLR, S_INIT, S_PRE, S_MOVE, S_EXEC, S_DRAIN, S_DONE
  } state_t;

  state_t        state;
  logic [SW-1:0] step;
  logic [2:0]    cyc;
  logic [RW-1:0] dr;
  logic [CW-1:0] dc;

  logic [31:0]   top_mem  [COLS][DEPTH];
  logic [31:0]   left_mem [ROWS][DEPTH];
  logic [IW-1:0] tidx [COLS];
  logic [IW-1:0] lidx [ROWS];
  logic [31:0]   treg [ROWS][COLS];
  logic [31:0]   lreg [ROWS][COLS];
  logic [31:0]   prod [ROWS][COLS];
  logic [31:0]   acc  [ROWS][COLS];

  function automatic logic act(int r, int c, int s);
    return (s >= r + c) && (s <= r + c + DEPTH - 1);
  endfunction

  assign out_we   = (state == S_DRAIN);
  assign out_row  = dr;
  assign out_col  = dc;
  assign out_data = acc[dr][dc];
  assign done     = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (top_we)  top_mem[top_sel][top_addr]    <= top_wdata;
    if (left_we) left_mem[left_sel][left_addr] <= left_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      step  <= '0;
      cyc   <= '0;
      dr    <= '0;
      dc    <= '0;
      for (int c = 0; c < COLS; c++) tidx[c] <= '1;
      for (int r = 0; r < ROWS; r++) lidx[r] <= '1;
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          treg[r][c] <= '0;
          lreg[r][c] <= '0;
          prod[r][c] <= '0;
          acc[r][c]  <= '0;
        end
    end else begin
      case (state)
        S_IDLE: if (start) state <= S_CLR;
        S_CLR: begin
          for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) acc[r][c] <= '0;
          state <= S_INIT;
        end
        S_INIT: begin
          for (int c = 0; c < COLS; c++) tidx[c] <= '1;
          for (int r = 0; r < ROWS; r++) lidx[r] <= '1;
          state <= S_PRE;
        end
        S_PRE: begin
          tidx[0] <= tidx[0] + IW'(1);
          lidx[0] <= lidx[0] + IW'(1);
          step    <= '0;
          state   <= S_MOVE;
        end
        S_MOVE: begin
          for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
              if (act(r, c, int'(step))) begin
                treg[r][c] <= (r == 0) ? top_mem[c][tidx[c]]
                                       : treg[(r == 0) ? 0 : r - 1][c];
                lreg[r][c] <= (c == 0) ? left_mem[r][lidx[r]]
                                       : lreg[r][(c == 0) ? 0 : c - 1];
              end
          cyc   <= '0;
          state <= S_EXEC;
        end
        S_EXEC: begin
          if (cyc == 3'd0 && int'(step) < NSTEP - 1) begin
            for (int c = 0; c < COLS; c++)
              if (act(0, c, int'(step) + 1)) tidx[c] <= tidx[c] + IW'(1);
            for (int r = 0; r < ROWS; r++)
              if (act(r, 0, int'(step) + 1)) lidx[r] <= lidx[r] + IW'(1);
          end
          for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
              if (act(r, c, int'(step))) begin
                if (cyc == 3'd3) prod[r][c] <= treg[r][c] * lreg[r][c];
                if (cyc == 3'd4) acc[r][c]  <= acc[r][c] + prod[r][c];
              end
          cyc <= cyc + 3'd1;
          if (cyc == 3'd4) begin
            if (int'(step) == NSTEP - 1) begin
              dr    <= '0;
              dc    <= '0;
              state <= S_DRAIN;
            end else begin
              step  <= step + SW'(1);
              state <= S_MOVE;
            end
          end
        end
        S_DRAIN: begin
          if (dc == CW'(COLS - 1)) begin
            dc <= '0;
            if (dr == RW'(ROWS - 1)) state <= S_DONE;
            else dr <= dr + RW'(1);
          end else begin
            dc <= dc + CW'(1);
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_we) && $past(out_row) == RW'(ROWS - 1)
              && $past(out_col) == CW'(COLS - 1)));

  a_r3_row_major: assert property (@(posedge clk) disable iff (!rst_n)
    (out_we && $past(out_we)) |->
      ((out_row == $past(out_row) && out_col == $past(out_col) + CW'(1)) ||
       (out_col == '0 && out_row == $past(out_row) + RW'(1))));

  a_r10_first_index: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MOVE && $past(state) == S_PRE) |-> (tidx[0] == '0 && lidx[0] == '0));

  a_r7_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && start) |=> state != S_CLR);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (!out_we && !done));
endmodule

// File: tb/wavefront_matmul_bench.sv
module wavefront_matmul_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 2;
  localparam int COLS  = 3;
  localparam int DEPTH = 4;
  localparam int IW    = $clog2(DEPTH);
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int NSTEP = ROWS + COLS + DEPTH - 2;
  localparam int FIRST = 6 * NSTEP + 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic top_we = 0, left_we = 0;
  logic [CW-1:0] top_sel = '0;
  logic [RW-1:0] left_sel = '0;
  logic [IW-1:0] top_addr = '0, left_addr = '0;
  logic [31:0] top_wdata = '0, left_wdata = '0;
  logic out_we, done;
  logic [RW-1:0] out_row;
  logic [CW-1:0] out_col;
  logic [31:0] out_data;

  int checks = 0, fails = 0;
  logic [31:0] A [ROWS][DEPTH];
  logic [31:0] B [DEPTH][COLS];
  logic [31:0] expv [ROWS][COLS];
  logic [31:0] got [ROWS][COLS];

  wavefront_matmul #(.ROWS(ROWS), .COLS(COLS), .TOP_DEPTH(DEPTH), .LEFT_DEPTH(DEPTH)) u_wavefront_matmul (
    .clk, .rst_n, .start, .top_we, .top_sel, .top_addr, .top_wdata,
    .left_we, .left_sel, .left_addr, .left_wdata,
    .out_we, .out_row, .out_col, .out_data, .done);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  function automatic void reference();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        logic [31:0] s = 0;
        for (int k = 0; k < DEPTH; k++) s = s + A[r][k] * B[k][c];
        expv[r][c] = s;
      end
  endfunction

  task automatic load();
    for (int c = 0; c < COLS; c++)
      for (int k = 0; k < DEPTH; k++) begin
        @(negedge clk);
        top_we = 1; top_sel = CW'(c); top_addr = IW'(k); top_wdata = B[k][c];
      end
    for (int r = 0; r < ROWS; r++)
      for (int k = 0; k < DEPTH; k++) begin
        @(negedge clk);
        top_we = 0; left_we = 1; left_sel = RW'(r); left_addr = IW'(k); left_wdata = A[r][k];
      end
    @(negedge clk);
    top_we = 0; left_we = 0;
  endtask

  task automatic run(input string tag, input bit poke);
    int n, wr;
    bit fin;
    reference();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    n = 1; wr = 0; fin = 0;
    while (!fin) begin
      start = (poke && n == 10);
      if (out_we) begin
        if (wr == 0) check("R5 first write edge", n, FIRST);
        check("R3 write order", {out_row, out_col}, {RW'(wr / COLS), CW'(wr % COLS)});
        if (wr < ROWS * COLS) got[wr / COLS][wr % COLS] = out_data;
        wr++;
      end
      if (done) begin
        check("R4 done edge", n, FIRST + ROWS * COLS);
        check("R3 write count", wr, ROWS * COLS);
        fin = 1;
      end else if (n > FIRST + 200) begin
        check("R4 done missing", 0, 1);
        fin = 1;
      end else begin
        @(negedge clk);
        n++;
      end
    end
    start = 0;
    @(negedge clk);
    check("R4 done one cycle", done, 0);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) check(tag, got[r][c], expv[r][c]);
  endtask

  task automatic fill_rand(input bit wide);
    for (int r = 0; r < ROWS; r++)
      for (int k = 0; k < DEPTH; k++) A[r][k] = wide ? $urandom : ($urandom % 256);
    for (int k = 0; k < DEPTH; k++)
      for (int c = 0; c < COLS; c++) B[k][c] = wide ? $urandom : ($urandom % 256);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 done in reset", done, 0);
    check("R1 out_we in reset", out_we, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 done after reset", done, 0);
    check("R1 out_we after reset", out_we, 0);

    for (int r = 0; r < ROWS; r++) for (int k = 0; k < DEPTH; k++) A[r][k] = (k == 0) ? r + 1 : 0;
    for (int k = 0; k < DEPTH; k++) for (int c = 0; c < COLS; c++) B[k][c] = (k == 0) ? c + 2 : 0;
    load(); run("R10 address 0 only", 0);

    for (int r = 0; r < ROWS; r++) for (int k = 0; k < DEPTH; k++) A[r][k] = (k == DEPTH-1) ? r + 5 : 0;
    for (int k = 0; k < DEPTH; k++) for (int c = 0; c < COLS; c++) B[k][c] = (k == DEPTH-1) ? 3*c + 1 : 0;
    load(); run("R10 last address only", 0);

    for (int r = 0; r < ROWS; r++) for (int k = 0; k < DEPTH; k++) A[r][k] = k + 10*r + 1;
    for (int k = 0; k < DEPTH; k++) for (int c = 0; c < COLS; c++) B[k][c] = 7*k + c + 1;
    load(); run("R2 ramp product", 0);

    for (int r = 0; r < ROWS; r++) for (int k = 0; k < DEPTH; k++) A[r][k] = '1;
    for (int k = 0; k < DEPTH; k++) for (int c = 0; c < COLS; c++) B[k][c] = '1;
    load(); run("R8 all ones wrap", 0);

    fill_rand(0); load(); run("R2 random small", 0);
    fill_rand(1); load(); run("R8 random full width", 0);
    run("R6 repeated run", 0);
    fill_rand(1); load(); run("R7 stray start", 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule